// File: doc/BRIEF.md
# Scatter-Gather Segment List Walker

This block turns a source description into an ordered stream of (address, length) segments for a hash datapath. When scatter-gather is enabled, it reads a list of 8-byte entries from memory. Each entry holds a length word followed by an address word. The list starts at a given base address, and entry i sits at base + 8*i. The block reads the two 32-bit little-endian words of each entry through a single-outstanding memory read port and presents one segment per entry on a valid/ready output. Bit 31 of an entry's length word marks the final entry.

When scatter-gather is disabled, the block skips the memory and emits one segment built from a direct source address and a 28-bit direct length.

A walk that reaches the entry limit without seeing an end marker stops with an error flag. Every walk ends with a one-cycle completion pulse. The block then waits in idle for the next start.

Top module: `sg_walker`

## Requirements
- R1: After reset, seg_valid, mem_req, done and err are all low.
- R2: For each entry the length word (byte address base + 8*i) is requested before the address word (base + 8*i + 4). Each request is a one-cycle mem_req pulse, and no new request is made while one awaits mem_rvalid.
- R3: seg_len equals bits [27:0] of the entry's length word; bits [30:28] of that word do not appear in the segment.
- R4: seg_addr equals the entry's address word with bit 31 forced to 0.
- R5: An entry whose length word has bit 31 set is emitted with seg_last = 1. After it is accepted, no further memory request is made.
- R6: An entry with a length of zero is still emitted as a segment with seg_len = 0.
- R7: If MAX_ENT (default 256) segments have been accepted and none was marked last, the walk stops without further requests and err goes high. err stays high until the next accepted start.
- R8: With sg_en = 0 at start, exactly one segment is emitted with seg_addr = direct_addr with bit 31 cleared, seg_len = direct_len and seg_last = 1, and no memory request is made.
- R9: While seg_valid is high and seg_ready is low, seg_valid, seg_addr, seg_len and seg_last do not change.
- R10: done is a single-cycle pulse. It is high in the cycle right after the final segment is accepted or after the error stop.
- R11: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| sg_en | input | 1 | 1: walk the list in memory, 0: emit the direct segment |
| list_base | input | 32 | Byte address of the first list entry |
| direct_addr | input | 32 | Source address used when sg_en is 0 |
| direct_len | input | LEN_W | Source length used when sg_en is 0 |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Downstream accepts the segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| seg_last | output | 1 | Segment is the final one of the walk |
| done | output | 1 | Walk finished (one cycle) |
| err | output | 1 | Walk stopped at the entry limit without an end marker |

## Verification
The checker watches several behaviours on every cycle:
- The segment output holds steady under backpressure.
- At most one memory request is outstanding at a time.
- No request is made in direct mode.
- Requests stop after the last segment or the limit.
- err rises only once the limit count of accepted segments is reached.
- done lasts one cycle and follows the accepted last segment.

Other behaviours can only be shown by the bench's scenarios:
- Masking of the length and address fields.
- The exact request address order.
- Zero-length entries passing through.
- The 256-entry error walk.
- Clearing err on the next start.
- A start pulse ignored mid-walk.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W   = 32;
  localparam int MARK_BIT = WORD_W - 1;
  localparam int ENT_BYTES = 8;
  localparam int ADR_OFS   = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEN,
    ST_ADR,
    ST_OUT
  } sgw_state_t;
endpackage

// File: rtl/sgw_entry_ctr.sv
module sgw_entry_ctr #(
  parameter int MAX_ENT = 256,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [AW-1:0] base,
  output logic          at_limit,
  output logic [AW-1:0] adr_addr,
  output logic [AW-1:0] nxt_len_addr
);
  localparam int IW = (MAX_ENT > 2) ? $clog2(MAX_ENT) : 1;

  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic [AW-1:0] ent_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      base_q <= '0;
    end else if (clr) begin
      idx    <= '0;
      base_q <= base;
    end else if (inc) begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    ent_ofs      = AW'(idx) * AW'(sgw_pkg::ENT_BYTES);
    adr_addr     = base_q + ent_ofs + AW'(sgw_pkg::ADR_OFS);
    nxt_len_addr = base_q + ent_ofs + AW'(sgw_pkg::ENT_BYTES);
    at_limit     = (idx == IW'(MAX_ENT - 1));
  end
endmodule

// File: rtl/sgw_seg_reg.sv
module sgw_seg_reg #(
  parameter int AW = 32,
  parameter int LW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          ld_last,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] len,
  output logic          last,
  output logic          fire
);
  assign fire = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      len   <= '0;
      last  <= 1'b0;
    end else if (load && !valid) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      len   <= ld_len;
      last  <= ld_last;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int MAX_ENT = 256,
  parameter int LEN_W   = 28,
  parameter int ADR_W   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sg_en,
  input  logic [WORD_W-1:0] list_base,
  input  logic [WORD_W-1:0] direct_addr,
  input  logic [LEN_W-1:0]  direct_len,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [WORD_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              done,
  output logic              err
);
  localparam logic [WORD_W-1:0] ADR_MASK = WORD_W'((64'd1 << ADR_W) - 64'd1);

  sgw_state_t        state;
  logic [LEN_W-1:0]  len_q;
  logic              mark_q;
  logic              accept;
  logic              busy;
  logic              ctr_clr;
  logic              ctr_inc;
  logic              at_limit;
  logic [WORD_W-1:0] adr_addr;
  logic [WORD_W-1:0] nxt_len_addr;
  logic              seg_load;
  logic [WORD_W-1:0] ld_addr;
  logic [LEN_W-1:0]  ld_len;
  logic              ld_last;
  logic              seg_fire;

  assign busy    = (state != ST_IDLE);
  assign accept  = start && !busy;
  assign ctr_clr = accept && sg_en;
  assign ctr_inc = (state == ST_OUT) && seg_fire && !seg_last && !at_limit;

  always_comb begin
    if (state == ST_IDLE) begin
      seg_load = accept && !sg_en;
      ld_addr  = direct_addr & ADR_MASK;
      ld_len   = direct_len;
      ld_last  = 1'b1;
    end else begin
      seg_load = (state == ST_ADR) && mem_rvalid;
      ld_addr  = mem_rdata & ADR_MASK;
      ld_len   = len_q;
      ld_last  = mark_q;
    end
  end

  sgw_entry_ctr #(.MAX_ENT(MAX_ENT), .AW(WORD_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(ctr_inc), .base(list_base),
    .at_limit(at_limit), .adr_addr(adr_addr), .nxt_len_addr(nxt_len_addr)
  );

  sgw_seg_reg #(.AW(WORD_W), .LW(LEN_W)) u_seg (
    .clk(clk), .rst(rst), .load(seg_load), .ld_addr(ld_addr), .ld_len(ld_len),
    .ld_last(ld_last), .ready(seg_ready), .valid(seg_valid), .addr(seg_addr),
    .len(seg_len), .last(seg_last), .fire(seg_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      mark_q   <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            err <= 1'b0;
            if (sg_en) begin
              mem_req  <= 1'b1;
              mem_addr <= list_base;
              state    <= ST_LEN;
            end else begin
              state <= ST_OUT;
            end
          end
        end
        ST_LEN: begin
          if (mem_rvalid) begin
            len_q    <= mem_rdata[LEN_W-1:0];
            mark_q   <= mem_rdata[MARK_BIT];
            mem_req  <= 1'b1;
            mem_addr <= adr_addr;
            state    <= ST_ADR;
          end
        end
        ST_ADR: begin
          if (mem_rvalid) state <= ST_OUT;
        end
        ST_OUT: begin
          if (seg_fire) begin
            if (seg_last) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (at_limit) begin
              done  <= 1'b1;
              err   <= 1'b1;
              state <= ST_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= nxt_len_addr;
              state    <= ST_LEN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_chk.sv
module sgw_chk #(
  parameter int MAX_ENT = 256,
  parameter int LEN_W   = 28
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        sg_en,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        seg_valid,
  input logic        seg_ready,
  input logic [31:0] seg_addr,
  input logic [LEN_W-1:0] seg_len,
  input logic        seg_last,
  input logic        done,
  input logic        err
);
  localparam int CW = $clog2(MAX_ENT + 1) + 1;

  logic          pend;
  logic          mode_sg;
  logic          ended;
  logic [CW-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      mode_sg <= 1'b0;
      ended   <= 1'b0;
      acc_cnt <= '0;
    end else begin
      if (mem_req) pend <= 1'b1;
      else if (mem_rvalid) pend <= 1'b0;
      if (start && !busy) begin
        mode_sg <= sg_en;
        ended   <= 1'b0;
        acc_cnt <= '0;
      end else if (seg_valid && seg_ready) begin
        acc_cnt <= acc_cnt + 1'b1;
        if (seg_last) ended <= 1'b1;
      end
    end
  end

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pend);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_no_req_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ended);
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && seg_ready && seg_last) |=> (done && !seg_valid));
  assert_limit_no_req_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (int'(acc_cnt) < MAX_ENT));
  assert_err_at_limit_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (int'(acc_cnt) == MAX_ENT));
  assert_direct_no_mem_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mode_sg);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) &&
                                   $stable(seg_len) && $stable(seg_last)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind sg_walker sgw_chk #(.MAX_ENT(MAX_ENT), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sg_en(sg_en), .busy(busy),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .seg_valid(seg_valid),
  .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
  .seg_last(seg_last), .done(done), .err(err)
);

// File: tb/sim_sg_walker.sv
module sim_sg_walker;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sg_en = 1'b0;
  logic [31:0] list_base = '0;
  logic [31:0] direct_addr = '0;
  logic [LW-1:0] direct_len = '0;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic seg_valid;
  logic seg_ready = 1'b1;
  logic [31:0] seg_addr;
  logic [LW-1:0] seg_len;
  logic seg_last;
  logic done;
  logic err;

  sg_walker u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem [0:2047];
  logic [31:0] got_addr [0:299];
  logic [LW-1:0] got_len [0:299];
  logic got_last [0:299];
  logic [31:0] req_log [0:599];
  int n_got, n_req, done_seen, cyc, fire_cyc, done_cyc;
  bit stall = 1'b0;
  int wcnt = 0;
  bit pend = 1'b0;
  logic [31:0] pend_addr = '0;
  bit held_v = 1'b0;
  logic [31:0] h_addr;
  logic [LW-1:0] h_len;
  logic h_last;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory responder: one-cycle latency after the request cycle
  always @(negedge clk) begin
    mem_rvalid = pend;
    mem_rdata  = pend ? mem[pend_addr[12:2]] : 32'h0;
    pend = (mem_req === 1'b1);
    pend_addr = mem_addr;
    if (mem_req === 1'b1 && n_req < 600) begin
      req_log[n_req] = mem_addr;
      n_req++;
    end
  end

  // ready driver and output monitor
  always @(negedge clk) begin
    cyc++;
    if (!stall) seg_ready = 1'b1;
    else if (seg_valid === 1'b1) begin
      seg_ready = (wcnt >= 2);
      wcnt = seg_ready ? 0 : wcnt + 1;
    end else begin
      seg_ready = 1'b0;
      wcnt = 0;
    end
    if (held_v) begin
      // R9: values held while stalled
      chk(seg_valid === 1'b1 && seg_addr === h_addr && seg_len === h_len && seg_last === h_last,
          "R9 hold", {32'h0, seg_addr}, {32'h0, h_addr});
    end
    held_v = (seg_valid === 1'b1) && !seg_ready;
    h_addr = seg_addr; h_len = seg_len; h_last = seg_last;
    if (seg_valid === 1'b1 && seg_ready && n_got < 300) begin
      got_addr[n_got] = seg_addr;
      got_len[n_got]  = seg_len;
      got_last[n_got] = seg_last;
      n_got++;
      if (seg_last) fire_cyc = cyc;
    end
    if (done === 1'b1) begin
      done_seen++;
      done_cyc = cyc;
    end
  end

  task automatic launch(input bit sg, input logic [31:0] base, input logic [31:0] da, input logic [LW-1:0] dl);
    n_got = 0; n_req = 0; done_seen = 0; fire_cyc = -1; done_cyc = -1;
    @(negedge clk);
    sg_en = sg; list_base = base; direct_addr = da; direct_len = dl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_wait();
    int t = 0;
    while (done_seen == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(done_seen == 1, "R10 one done pulse", done_seen, 1);
  endtask

  // direct-mode vectors: {direct_addr, direct_len, exp_addr, exp_len}
  localparam logic [127:0] DVEC [4] = '{
    {32'h0000_1000, 32'h0000_0040, 32'h0000_1000, 32'h0000_0040},
    {32'h8000_0004, 32'h0FFF_FFFF, 32'h0000_0004, 32'h0FFF_FFFF},
    {32'hFFFF_FFF8, 32'h0000_0000, 32'h7FFF_FFF8, 32'h0000_0000},
    {32'h1234_5678, 32'h0ABC_DEF1, 32'h1234_5678, 32'h0ABC_DEF1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    for (int i = 0; i < 256; i++) begin
      mem[2*i]   = 32'(i);
      mem[2*i+1] = 32'h8000_0000 | 32'(i * 16);
    end
    mem[1024] = 32'h7000_0010; mem[1025] = 32'hFFFF_F000;
    mem[1026] = 32'h0000_0000; mem[1027] = 32'h1234_5678;
    mem[1028] = 32'h8FFF_FFFF; mem[1029] = 32'h8000_0004;
    mem[1030] = 32'h0000_0099; mem[1031] = 32'h0000_0888;
    mem[1088] = 32'h8000_0005; mem[1089] = 32'h0000_2000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(seg_valid === 1'b0 && mem_req === 1'b0 && done === 1'b0 && err === 1'b0,
        "R1 reset outputs", {seg_valid, mem_req, done, err}, 0);

    // R8 direct mode vectors
    for (int v = 0; v < 4; v++) begin
      launch(1'b0, 32'h0, DVEC[v][127:96], DVEC[v][64+LW-1:64]);
      finish_wait();
      chk(n_got == 1, "R8 one segment", n_got, 1);
      chk(got_addr[0] === DVEC[v][63:32], "R8 addr", got_addr[0], DVEC[v][63:32]);
      chk(got_len[0] === DVEC[v][LW-1:0], "R8 len", got_len[0], DVEC[v][LW-1:0]);
      chk(got_last[0] === 1'b1, "R8 last", got_last[0], 1);
      chk(n_req == 0, "R8 no memory request", n_req, 0);
      chk(done_cyc == fire_cyc + 1, "R10 done timing", done_cyc, fire_cyc + 1);
    end

    // three-entry list with backpressure
    stall = 1'b1;
    launch(1'b1, 32'h0000_1000, 32'h0, '0);
    finish_wait();
    chk(n_got == 3, "R5 segment count", n_got, 3);
    chk(got_len[0] === 28'h000_0010, "R3 len bits masked", got_len[0], 28'h10);
    chk(got_addr[0] === 32'h7FFF_F000, "R4 addr bit31 cleared", got_addr[0], 32'h7FFF_F000);
    chk(got_len[1] === 28'h0 && got_addr[1] === 32'h1234_5678, "R6 zero-length entry",
        {got_addr[1], 4'h0, got_len[1]}, {32'h1234_5678, 32'h0});
    chk(got_last[0] === 1'b0 && got_last[1] === 1'b0 && got_last[2] === 1'b1, "R5 last flag",
        {got_last[0], got_last[1], got_last[2]}, 3'b001);
    chk(got_len[2] === 28'hFFF_FFFF && got_addr[2] === 32'h0000_0004, "R3 R4 final entry",
        {got_addr[2], 4'h0, got_len[2]}, {32'h4, 32'h0FFF_FFFF});
    chk(n_req == 6, "R5 no request past end", n_req, 6);
    for (int k = 0; k < 6; k++)
      chk(req_log[k] === 32'h1000 + 32'(4 * k), "R2 request order", req_log[k], 32'h1000 + 32'(4 * k));
    chk(done_cyc == fire_cyc + 1, "R10 done after last accept", done_cyc, fire_cyc + 1);
    chk(err === 1'b0, "R7 no error on marked list", err, 0);

    // R11: start while busy is ignored
    launch(1'b1, 32'h0000_1100, 32'h0, '0);
    sg_en = 1'b0; direct_addr = 32'h0000_0ABC; direct_len = 28'h77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait();
    chk(n_got == 1 && got_addr[0] === 32'h0000_2000 && got_len[0] === 28'h5,
        "R11 start ignored when busy", {got_addr[0], 4'h0, got_len[0]}, {32'h2000, 32'h5});
    stall = 1'b0;

    // R7: list with no end marker
    launch(1'b1, 32'h0, 32'h0, '0);
    finish_wait();
    chk(n_got == 256, "R7 segments before stop", n_got, 256);
    chk(err === 1'b1, "R7 error flag", err, 1);
    begin
      int lastcnt = 0;
      for (int k = 0; k < 256; k++) lastcnt += int'(got_last[k]);
      chk(lastcnt == 0, "R7 no last flag", lastcnt, 0);
    end
    chk(got_addr[255] === 32'h0000_0FF0 && got_len[255] === 28'd255, "R7 R4 final segment",
        {got_addr[255], 4'h0, got_len[255]}, {32'hFF0, 32'd255});
    chk(n_req == 512 && req_log[511] === 32'h0000_07FC, "R7 no request past limit",
        {n_req[31:0], req_log[511]}, {32'd512, 32'h7FC});
    repeat (5) @(negedge clk);
    chk(err === 1'b1, "R7 error held while idle", err, 1);

    launch(1'b0, 32'h0, 32'h40, 28'h8);
    finish_wait();
    chk(err === 1'b0, "R7 error cleared by start", err, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule